// File: doc/BRIEF.md
# Processor Status Word and Interrupt Acceptance Unit

This block holds the processor status word of a small CPU core. The word carries the ALU condition bits, a debug bit, a register-bank select, a global interrupt enable, a stack select and a 3-bit processor priority level. The same block decides, cycle by cycle, whether a pending maskable hardware interrupt or a software trap instruction is taken. When one is taken, it captures the old status word for the stacking logic and changes the word as the interrupt entry rules require.

Two 16-bit stack pointer registers also live here: one for interrupt context and one for user context. The stack-select bit of the word picks which one drives the current stack pointer output. The bank-select bit is passed out to an external register file. Three things sit outside this block: the instruction decoder, which issues full-word writes and trap requests; the ALU, which supplies result flags with one update enable per flag; and the sequencer, which fetches the vector and pushes the saved word.

Top module: `cpu_status_unit`

## Requirements
- R1: After reset the status word, the saved word, both stack pointers, the bank select and the accept pulse are all 0. This selects the interrupt stack pointer and disables maskable interrupts.
- R2: The word layout is: bit 0 carry, bit 1 debug, bit 2 zero, bit 3 sign, bit 4 bank select, bit 5 overflow, bit 6 interrupt enable, bit 7 stack select, and bits 14:12 priority level. On `alu_flag_en` the index order is 0 carry, 1 zero, 2 sign, 3 overflow. At a clock edge, each of these four bits takes its `alu_flag_val` bit only when its enable bit is 1. Every other bit keeps its value.
- R3: With `psw_wr_en` high, the whole word is loaded from `psw_wr_data` at the next edge. Reserved bits 15 and 11:8 always read 0. A full-word write takes priority over ALU updates in the same cycle.
- R4: A hardware request is accepted only when the interrupt enable (bit 6) is 1 and `hw_irq_lvl` is strictly greater than the priority level field (bits 14:12). Acceptance shows as `irq_accept` high for the one cycle that follows the deciding edge.
- R5: On hardware acceptance, the interrupt enable and the stack select are cleared, the priority field is loaded with `hw_irq_lvl`, and all other bits are kept.
- R6: A software trap (`sw_int_req`) is always accepted, whatever the enable and priority state. It clears the interrupt enable. It clears the stack select only for `sw_int_vec` below 32, and it leaves the priority level unchanged. When it coincides with a hardware request, the trap is taken and the hardware request is not.
- R7: On any acceptance, `saved_psw` captures the word as it stood before the change. It holds that value until the next acceptance.
- R8: In an accepting cycle, a full-word write and ALU updates issued in that cycle are discarded.
- R9: `sp_cur` shows the user pointer when the stack select is 1 and the interrupt pointer when it is 0. `isp_we` and `usp_we` load `sp_wdata` into the respective pointer, and each pointer is otherwise unchanged.
- R10: `bank_sel` always equals bit 4 of the status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_flag_val | input | 4 | ALU result flags: carry, zero, sign, overflow |
| alu_flag_en | input | 4 | Update enable per ALU flag |
| psw_wr_en | input | 1 | Full-word write strobe |
| psw_wr_data | input | 16 | Full-word write value |
| hw_irq_req | input | 1 | Maskable hardware interrupt request |
| hw_irq_lvl | input | 3 | Priority of the hardware request |
| sw_int_req | input | 1 | Software trap request |
| sw_int_vec | input | 6 | Software trap vector number |
| isp_we | input | 1 | Interrupt stack pointer write |
| usp_we | input | 1 | User stack pointer write |
| sp_wdata | input | 16 | Stack pointer write value |
| psw | output | 16 | Current status word |
| irq_accept | output | 1 | One-cycle acceptance pulse |
| saved_psw | output | 16 | Word captured before the last acceptance |
| sp_cur | output | 16 | Selected stack pointer |
| bank_sel | output | 1 | Register bank select |

## Verification
The bench builds the unit with its default parameters: 16-bit stack pointers, 6-bit trap vectors and a stack-switch limit of 32. At these values every combination of processor level, request level and enable state (128 cases) can be swept, along with all 64 trap vectors on both sides of the limit and all 256 pairings of ALU enable mask and flag values. The same widths keep the coincidence cases within reach of direct checks: a trap against a hardware request, and acceptance against a full-word write.

// File: rtl/cpu_psw_pkg.sv
package cpu_psw_pkg;
  localparam int unsigned PSW_W   = 16;
  localparam int unsigned BIT_C   = 0;
  localparam int unsigned BIT_D   = 1;
  localparam int unsigned BIT_Z   = 2;
  localparam int unsigned BIT_S   = 3;
  localparam int unsigned BIT_B   = 4;
  localparam int unsigned BIT_O   = 5;
  localparam int unsigned BIT_I   = 6;
  localparam int unsigned BIT_U   = 7;
  localparam int unsigned LVL_LSB = 12;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned LVL_MSB = LVL_LSB + LVL_W - 1;
  localparam int unsigned N_ALU   = 4;
  // ALU flag index -> word bit: carry, zero, sign, overflow
  localparam int unsigned ALU_POS [N_ALU] = '{BIT_C, BIT_Z, BIT_S, BIT_O};
  // bits that hold state; all others read as zero
  localparam logic [PSW_W-1:0] KEEP_MASK = 16'h70FF;

  typedef logic [PSW_W-1:0] psw_t;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/psw_irq_arbiter.sv
module psw_irq_arbiter
  import cpu_psw_pkg::*;
#(
  parameter int unsigned VEC_W      = 6,
  parameter int unsigned SW_U_LIMIT = 32
) (
  input  logic             ien,
  input  lvl_t             cur_lvl,
  input  logic             hw_req,
  input  lvl_t             hw_lvl,
  input  logic             sw_req,
  input  logic [VEC_W-1:0] sw_vec,
  output logic             take,
  output logic             take_hw,
  output logic             clr_user
);
  localparam logic [VEC_W:0] LIMIT = SW_U_LIMIT[VEC_W:0];

  logic hw_ok;
  logic sw_low;

  always_comb begin
    hw_ok    = hw_req && ien && (hw_lvl > cur_lvl);
    sw_low   = ({1'b0, sw_vec} < LIMIT);
    take_hw  = hw_ok && !sw_req;
    take     = sw_req || hw_ok;
    clr_user = take_hw || (sw_req && sw_low);
  end
endmodule

// File: rtl/psw_next_word.sv
module psw_next_word
  import cpu_psw_pkg::*;
(
  input  psw_t             cur,
  input  logic             take,
  input  logic             take_hw,
  input  logic             clr_user,
  input  lvl_t             hw_lvl,
  input  logic             wr_en,
  input  psw_t             wr_data,
  input  logic [N_ALU-1:0] alu_val,
  input  logic [N_ALU-1:0] alu_en,
  output psw_t             nxt,
  output logic             load
);
  always_comb begin
    nxt = cur;
    if (take) begin
      nxt[BIT_I] = 1'b0;
      if (clr_user) nxt[BIT_U] = 1'b0;
      if (take_hw)  nxt[LVL_MSB:LVL_LSB] = hw_lvl;
    end else if (wr_en) begin
      nxt = wr_data & KEEP_MASK;
    end else begin
      for (int k = 0; k < N_ALU; k++) begin
        if (alu_en[k]) nxt[ALU_POS[k]] = alu_val[k];
      end
    end
    load = take || wr_en || (|alu_en);
  end
endmodule

// File: rtl/psw_stack_ptrs.sv
module psw_stack_ptrs #(
  parameter int unsigned SP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            isp_we,
  input  logic            usp_we,
  input  logic [SP_W-1:0] wdata,
  input  logic            use_user,
  output logic [SP_W-1:0] sp_out
);
  logic [SP_W-1:0] isp_q, isp_d;
  logic [SP_W-1:0] usp_q, usp_d;

  always_comb begin
    isp_d  = wdata;
    usp_d  = wdata;
    sp_out = use_user ? usp_q : isp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isp_q <= '0;
    else if (isp_we) isp_q <= isp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      usp_q <= '0;
    else if (usp_we) usp_q <= usp_d;
  end

  // R9: pointers change only on their own write strobe
  p_isp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !isp_we |=> $stable(isp_q));
  p_usp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !usp_we |=> $stable(usp_q));
endmodule

// File: rtl/cpu_status_unit.sv
module cpu_status_unit
  import cpu_psw_pkg::*;
#(
  parameter int unsigned SP_W       = 16,
  parameter int unsigned VEC_W      = 6,
  parameter int unsigned SW_U_LIMIT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       alu_flag_val,
  input  logic [3:0]       alu_flag_en,
  input  logic             psw_wr_en,
  input  logic [15:0]      psw_wr_data,
  input  logic             hw_irq_req,
  input  logic [2:0]       hw_irq_lvl,
  input  logic             sw_int_req,
  input  logic [VEC_W-1:0] sw_int_vec,
  input  logic             isp_we,
  input  logic             usp_we,
  input  logic [SP_W-1:0]  sp_wdata,
  output logic [15:0]      psw,
  output logic             irq_accept,
  output logic [15:0]      saved_psw,
  output logic [SP_W-1:0]  sp_cur,
  output logic             bank_sel
);
  psw_t flags_q, flags_d, saved_q;
  logic acc_q;
  logic take, take_hw, clr_user, load;

  psw_irq_arbiter #(.VEC_W(VEC_W), .SW_U_LIMIT(SW_U_LIMIT)) u_arb (
    .ien      (flags_q[BIT_I]),
    .cur_lvl  (flags_q[LVL_MSB:LVL_LSB]),
    .hw_req   (hw_irq_req),
    .hw_lvl   (hw_irq_lvl),
    .sw_req   (sw_int_req),
    .sw_vec   (sw_int_vec),
    .take     (take),
    .take_hw  (take_hw),
    .clr_user (clr_user)
  );

  psw_next_word u_next (
    .cur      (flags_q),
    .take     (take),
    .take_hw  (take_hw),
    .clr_user (clr_user),
    .hw_lvl   (hw_irq_lvl),
    .wr_en    (psw_wr_en),
    .wr_data  (psw_wr_data),
    .alu_val  (alu_flag_val),
    .alu_en   (alu_flag_en),
    .nxt      (flags_d),
    .load     (load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags_q <= '0;
    else if (load) flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    saved_q <= '0;
    else if (take) saved_q <= flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= take;
  end

  psw_stack_ptrs #(.SP_W(SP_W)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .isp_we   (isp_we),
    .usp_we   (usp_we),
    .wdata    (sp_wdata),
    .use_user (flags_q[BIT_U]),
    .sp_out   (sp_cur)
  );

  assign psw        = flags_q;
  assign saved_psw  = saved_q;
  assign irq_accept = acc_q;
  assign bank_sel   = flags_q[BIT_B];

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (psw & ~KEEP_MASK) == '0);
  p_accept_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |-> ($past(psw[BIT_I]) || $past(sw_int_req)));
  p_accept_clears_ien_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |-> !psw[BIT_I]);
  p_hw_loads_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_accept && !$past(sw_int_req)) |-> (psw[LVL_MSB:LVL_LSB] == $past(hw_irq_lvl)));
  p_sw_keeps_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_accept && $past(sw_int_req)) |-> $stable(psw[LVL_MSB:LVL_LSB]));
  p_saved_is_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |-> (saved_psw == $past(psw)));
endmodule

// File: tb/cpu_status_unit_bench.sv
module cpu_status_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  alu_flag_val, alu_flag_en;
  logic        psw_wr_en;
  logic [15:0] psw_wr_data;
  logic        hw_irq_req;
  logic [2:0]  hw_irq_lvl;
  logic        sw_int_req;
  logic [5:0]  sw_int_vec;
  logic        isp_we, usp_we;
  logic [15:0] sp_wdata;
  logic [15:0] psw, saved_psw, sp_cur;
  logic        irq_accept, bank_sel;

  int checks = 0;
  int errors = 0;
  localparam logic [15:0] KEEP = 16'h70FF;

  always #4 clk = ~clk;

  cpu_status_unit u_cpu_status_unit (
    .clk(clk), .rst_n(rst_n),
    .alu_flag_val(alu_flag_val), .alu_flag_en(alu_flag_en),
    .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data),
    .hw_irq_req(hw_irq_req), .hw_irq_lvl(hw_irq_lvl),
    .sw_int_req(sw_int_req), .sw_int_vec(sw_int_vec),
    .isp_we(isp_we), .usp_we(usp_we), .sp_wdata(sp_wdata),
    .psw(psw), .irq_accept(irq_accept), .saved_psw(saved_psw),
    .sp_cur(sp_cur), .bank_sel(bank_sel)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    alu_flag_val = '0; alu_flag_en = '0; psw_wr_en = 0; psw_wr_data = '0;
    hw_irq_req = 0; hw_irq_lvl = '0; sw_int_req = 0; sw_int_vec = '0;
    isp_we = 0; usp_we = 0; sp_wdata = '0;
  endtask

  // one clock edge, then settle 1 ns past it and drop strobes
  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic wr(input logic [15:0] w);
    psw_wr_en = 1; psw_wr_data = w;
    tick();
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 psw", psw, 16'h0);
    chk("R1 saved", saved_psw, 16'h0);
    chk("R1 accept", {15'b0, irq_accept}, 16'h0);
    chk("R1 sp", sp_cur, 16'h0);
    chk("R1 bank", {15'b0, bank_sel}, 16'h0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;

    // R3 reserved bits and full write; R10 bank
    wr(16'hFFFF);
    chk("R3 reserved", psw, KEEP);
    chk("R10 bank set", {15'b0, bank_sel}, 16'h1);
    wr(16'h0000);
    chk("R3 clear", psw, 16'h0);
    chk("R10 bank clr", {15'b0, bank_sel}, 16'h0);
    // R3 write beats ALU same cycle
    psw_wr_en = 1; psw_wr_data = 16'h0012; alu_flag_en = 4'hF; alu_flag_val = 4'hF;
    tick();
    chk("R3 write over alu", psw, 16'h0012);

    // R2 ALU update sweep
    for (int en = 0; en < 16; en++) begin
      for (int v = 0; v < 16; v++) begin
        logic [3:0] nv;
        logic [15:0] base, exp;
        nv = ~v[3:0];
        base = 16'h5092 | {10'b0, nv[3], 1'b0, nv[2], nv[1], 1'b0, nv[0]};
        wr(base);
        alu_flag_en = en[3:0]; alu_flag_val = v[3:0];
        tick();
        exp = base;
        if (en[0]) exp[0] = v[0];
        if (en[1]) exp[2] = v[1];
        if (en[2]) exp[3] = v[2];
        if (en[3]) exp[5] = v[3];
        chk("R2 alu update", psw, exp);
      end
    end

    // R4 R5 R7 hardware acceptance sweep
    for (int lv = 0; lv < 8; lv++) begin
      for (int ie = 0; ie < 2; ie++) begin
        for (int rq = 0; rq < 8; rq++) begin
          logic [15:0] pre, exp;
          logic acc;
          pre = (16'(lv) << 12) | (16'(ie) << 6) | 16'h0095;
          wr(pre);
          hw_irq_req = 1; hw_irq_lvl = rq[2:0];
          tick();
          acc = (ie == 1) && (rq > lv);
          chk("R4 accept", {15'b0, irq_accept}, {15'b0, acc});
          if (acc) begin
            exp = (pre & ~16'h70C0) | (16'(rq) << 12);
            chk("R5 hw entry", psw, exp);
            chk("R7 saved", saved_psw, pre);
          end else begin
            chk("R4 no change", psw, pre);
          end
          tick();
          chk("R4 single pulse", {15'b0, irq_accept}, 16'h0);
        end
      end
    end

    // R6 software trap sweep, interrupts disabled
    for (int vec = 0; vec < 64; vec++) begin
      logic [15:0] pre, exp;
      pre = 16'h5091;
      wr(pre);
      sw_int_req = 1; sw_int_vec = vec[5:0];
      tick();
      exp = (vec < 32) ? (pre & ~16'h0080) : pre;
      chk("R6 sw accept", {15'b0, irq_accept}, 16'h1);
      chk("R6 sw entry", psw, exp);
      chk("R7 sw saved", saved_psw, pre);
    end

    // R6 trap coinciding with hardware request
    wr(16'h00C0);
    sw_int_req = 1; sw_int_vec = 6'd40; hw_irq_req = 1; hw_irq_lvl = 3'd7;
    tick();
    chk("R6 sw over hw", psw, 16'h0080);
    chk("R6 sw over hw accept", {15'b0, irq_accept}, 16'h1);
    // R7 saved holds without acceptance
    wr(16'h0003);
    chk("R7 saved hold", saved_psw, 16'h00C0);

    // R8 acceptance beats write and ALU
    wr(16'h00C0);
    hw_irq_req = 1; hw_irq_lvl = 3'd3; psw_wr_en = 1; psw_wr_data = 16'h0011;
    alu_flag_en = 4'hF; alu_flag_val = 4'hF;
    tick();
    chk("R8 accept wins", psw, 16'h3000);

    // R9 stack pointers
    isp_we = 1; sp_wdata = 16'h1234; tick();
    usp_we = 1; sp_wdata = 16'hBEEF; tick();
    wr(16'h0000);
    chk("R9 isp selected", sp_cur, 16'h1234);
    wr(16'h0080);
    chk("R9 usp selected", sp_cur, 16'hBEEF);
    usp_we = 1; sp_wdata = 16'h0F0F; tick();
    chk("R9 usp rewrite", sp_cur, 16'h0F0F);
    wr(16'h0000);
    chk("R9 isp unchanged", sp_cur, 16'h1234);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule